// File: doc/BRIEF.md
# Serial Flash Byte-Program Sequencer

This block runs one serial-flash transaction at a time from a fast system clock. It drives the serial clock, the active-low chip select and the serial data output, and it samples the serial data input. A program frame sends an instruction byte, then the address bytes with the most significant byte first, then one data byte. A read frame sends the instruction byte and then clocks in one byte, which it presents on `rdata`.

The serial clock is the system clock divided by two. It runs at that fixed rate inside every 8-bit byte. Between two bytes of the same frame the block can hold the serial clock low for a number of extra system clocks, chosen per frame, while chip select stays low. A user pulses `start` with the instruction, address, data, gap length and frame kind. The user then waits for the one-cycle `done` pulse.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is asserted, cs_n=1, sck=0, mosi=0, busy=0, done=0 and rdata=0x00.
- R2: sck is 0 whenever cs_n is 1. Within a byte, each bit holds sck high for exactly one system clock and then low for exactly one system clock. Every byte gives exactly 8 rising edges.
- R3: mosi changes only in the clock where sck falls, or when a frame is loaded, and never while sck is high. Each byte is sent most significant bit first.
- R4: With rd_mode=0, a frame carries opcode, addr[23:16], addr[15:8], addr[7:0] and wdata, in that order. That makes 40 rising edges of sck inside a single low period of cs_n.
- R5: Between consecutive bytes, sck stays low for gap_len+1 system clocks. A gap_len of 0 gives back-to-back bytes at the normal rate. cs_n stays low throughout.
- R6: With rd_mode=1, a frame sends the opcode and then 8 more bits with mosi=0, which makes 16 rising edges. miso is sampled at each rising edge of sck in the second byte, most significant bit first. The resulting byte appears on rdata when done pulses.
- R7: cs_n falls in the clock after start is accepted, which is one system clock before the first rising edge of sck. After the final falling edge, cs_n stays low for exactly one more system clock.
- R8: busy is high from the clock after an accepted start until 4 system clocks after cs_n rises. In the clock where busy falls, done is high for exactly one cycle.
- R9: A start pulse while busy is high is ignored. The frame in progress continues unchanged.
- R10: opcode, addr, wdata, gap_len and rd_mode are captured at an accepted start. Later changes to them do not affect the frame in progress. Later changes also leave rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| rd_mode | input | 1 | 1 = read frame, 0 = program frame |
| opcode | input | 8 | Instruction byte |
| addr | input | 24 | Byte address, sent most significant byte first |
| wdata | input | 8 | Data byte to program |
| gap_len | input | 8 | Extra low clocks of sck between bytes |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 8 | Byte captured by the last read frame |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Some rules are checked on every cycle by the assertions:
- sck stays low while cs_n is high.
- Each sck high phase lasts one clock.
- mosi stays stable while sck is high.
- cs_n leads the first sck rise.
- The gap never raises cs_n.
- busy only starts after a start pulse.
- done lasts a single cycle.

Other properties only the bench's scenarios can show:
- Whole-frame ordering of the bytes.
- Exact gap lengths for several values.
- The returned read byte.
- That a mid-frame start and changed inputs leave the frame and rdata untouched.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_GAP   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GUARD = 3'd4
  } fps_state_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/fps_shifter.sv
module fps_shifter
  import fps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              byte_end,
  output logic [BYTE_W-1:0] rx_next
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic              sck_q, sck_d;
  logic              mosi_q, mosi_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BIT_W-1:0]  bit_q, bit_d;

  assign sck      = sck_q;
  assign mosi     = mosi_q;
  assign rx_next  = {rx_q[BYTE_W-2:0], miso};
  assign byte_end = run && sck_q && (bit_q == LAST_BIT);

  always_comb begin
    sck_d  = sck_q;
    mosi_d = mosi_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    if (run) begin
      if (!sck_q) begin
        sck_d = 1'b1;
      end else begin
        sck_d = 1'b0;
        rx_d  = rx_next;
        if (bit_q != LAST_BIT) begin
          bit_d  = bit_q + 1'b1;
          tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
          mosi_d = tx_q[BYTE_W-2];
        end
      end
    end
    if (load) begin
      tx_d   = load_byte;
      mosi_d = load_byte[BYTE_W-1];
      bit_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
    end else begin
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
    end
  end

  AST_SCK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |=> !sck_q);  // R2
  AST_MOSI_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(mosi_q));  // R3
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int GAP_W      = 8,
  parameter int CS_GUARD   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    rd_mode,
  input  logic [BYTE_W-1:0]       opcode,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [BYTE_W-1:0]       wdata,
  input  logic [GAP_W-1:0]        gap_len,
  input  logic                    byte_end,
  input  logic [BYTE_W-1:0]       rx_next,
  output logic                    run,
  output logic                    load,
  output logic [BYTE_W-1:0]       load_byte,
  output logic                    cs_n,
  output logic                    busy,
  output logic                    done,
  output logic [BYTE_W-1:0]       rdata
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int IDX_W  = $clog2(ADDR_BYTES + 2);
  localparam int GRD_W  = $clog2(CS_GUARD + 1);
  localparam logic [IDX_W-1:0] PROG_LAST = IDX_W'(ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0] READ_LAST = IDX_W'(1);

  fps_state_e         st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d, nidx, last_idx;
  logic [GAP_W-1:0]   gcnt_q, gcnt_d, gap_q, gap_d;
  logic [GRD_W-1:0]   grd_q, grd_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [BYTE_W-1:0]  wd_q, wd_d, rdata_q, rdata_d, next_byte;
  logic               rd_q, rd_d, cs_n_q, cs_n_d, busy_q, busy_d, done_q, done_d;

  assign run      = (st_q == ST_SHIFT);
  assign cs_n     = cs_n_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign nidx     = idx_q + 1'b1;
  assign last_idx = rd_q ? READ_LAST : PROG_LAST;

  always_comb begin
    next_byte = wd_q;
    for (int k = 1; k <= ADDR_BYTES; k++) begin
      if (int'(nidx) == k) next_byte = addr_q[8*(ADDR_BYTES-k) +: 8];
    end
    if (rd_q) next_byte = '0;
  end

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    gcnt_d    = gcnt_q;
    grd_d     = grd_q;
    cs_n_d    = cs_n_q;
    busy_d    = busy_q;
    done_d    = 1'b0;
    rdata_d   = rdata_q;
    addr_d    = addr_q;
    wd_d      = wd_q;
    gap_d     = gap_q;
    rd_d      = rd_q;
    load      = 1'b0;
    load_byte = opcode;
    unique case (st_q)
      ST_IDLE: if (start) begin
        load   = 1'b1;
        st_d   = ST_SHIFT;
        cs_n_d = 1'b0;
        busy_d = 1'b1;
        idx_d  = '0;
        addr_d = addr;
        wd_d   = wdata;
        gap_d  = gap_len;
        rd_d   = rd_mode;
      end
      ST_SHIFT: if (byte_end) begin
        if (idx_q == last_idx) begin
          st_d = ST_HOLD;
          if (rd_q) rdata_d = rx_next;
        end else begin
          load      = 1'b1;
          load_byte = next_byte;
          idx_d     = nidx;
          if (gap_q != '0) begin
            st_d   = ST_GAP;
            gcnt_d = gap_q;
          end
        end
      end
      ST_GAP: begin
        if (gcnt_q <= GAP_W'(1)) st_d = ST_SHIFT;
        else gcnt_d = gcnt_q - 1'b1;
      end
      ST_HOLD: begin
        cs_n_d = 1'b1;
        st_d   = ST_GUARD;
        grd_d  = GRD_W'(CS_GUARD - 1);
      end
      ST_GUARD: begin
        if (grd_q == '0) begin
          st_d   = ST_IDLE;
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          grd_d = grd_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      gcnt_q  <= '0;
      grd_q   <= '0;
      cs_n_q  <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      gap_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      gcnt_q  <= gcnt_d;
      grd_q   <= grd_d;
      cs_n_q  <= cs_n_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
      addr_q  <= addr_d;
      wd_q    <= wd_d;
      gap_q   <= gap_d;
      rd_q    <= rd_d;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R8
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));  // R9
  AST_GAP_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> !cs_n_q);  // R5
  AST_CS_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> busy_q);  // R8
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int GAP_W      = 8,
  parameter int CS_GUARD   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    rd_mode,
  input  logic [7:0]              opcode,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [7:0]              wdata,
  input  logic [GAP_W-1:0]        gap_len,
  output logic                    busy,
  output logic                    done,
  output logic [7:0]              rdata,
  output logic                    sck,
  output logic                    cs_n,
  output logic                    mosi,
  input  logic                    miso
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              run, load, byte_end;
  logic [BYTE_W-1:0] load_byte, rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  fps_ctrl #(
    .ADDR_BYTES(ADDR_BYTES),
    .GAP_W     (GAP_W),
    .CS_GUARD  (CS_GUARD)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .rd_mode  (rd_mode),
    .opcode   (opcode),
    .addr     (addr),
    .wdata    (wdata),
    .gap_len  (gap_len),
    .byte_end (byte_end),
    .rx_next  (rx_next),
    .run      (run),
    .load     (load),
    .load_byte(load_byte),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata)
  );

  fps_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (run),
    .load     (load),
    .load_byte(load_byte),
    .miso     (miso),
    .sck      (sck),
    .mosi     (mosi),
    .byte_end (byte_end),
    .rx_next  (rx_next)
  );

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_n |-> !sck);  // R2
  AST_CS_LEADS_SCK: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(sck) |-> !$past(cs_n));  // R7
endmodule

// File: tb/flash_prog_seq_tb.sv
`timescale 1ns/1ps
module flash_prog_seq_tb;
  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
    logic busy;
    logic done;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_mode = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [23:0] addr = 24'h0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  gap_len = 8'h00;
  logic        miso = 1'b0;
  logic        busy, done, sck, cs_n, mosi;
  logic [7:0]  rdata;

  int    errors = 0;
  int    checks = 0;
  exp_t  q[$];
  logic  m_mosi = 1'b0;
  logic  mon_en = 1'b0;
  logic [7:0] flash_byte = 8'h00;
  int    exp_rises = 0;
  string tag = "R1";
  int    rises = 0;
  logic  prev_sck = 1'b0;
  logic  prev_cs = 1'b1;

  always #2.5 clk = ~clk;

  flash_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .opcode(opcode), .addr(addr), .wdata(wdata), .gap_len(gap_len),
    .busy(busy), .done(done), .rdata(rdata), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // flash side: present next read bit after each falling sck
  initial begin
    int falls = 0;
    forever begin
      @(negedge sck or posedge cs_n);
      #1;
      if (cs_n) begin
        falls = 0;
        miso  = 1'b0;
      end else begin
        falls++;
        if (falls >= 8 && falls < 16) miso = flash_byte[15-falls];
        else miso = 1'b0;
      end
    end
  end

  // cycle-by-cycle comparison against the reference queue
  always @(negedge clk) begin
    if (mon_en) begin
      exp_t e;
      if (q.size() != 0) e = q.pop_front();
      else e = '{cs_n: 1'b1, sck: 1'b0, mosi: m_mosi, busy: 1'b0, done: 1'b0};
      check({"R7 cs_n ", tag}, cs_n, e.cs_n);
      check({"R2 sck ", tag}, sck, e.sck);
      check({"R3 mosi ", tag}, mosi, e.mosi);
      check({"R8 busy ", tag}, busy, e.busy);
      check({"R8 done ", tag}, done, e.done);
      if (!cs_n && sck && !prev_sck) rises++;
      if (cs_n && !prev_cs) begin
        check({"R4/R6 rising edges ", tag}, rises, exp_rises);
        rises = 0;
      end
      prev_sck = sck;
      prev_cs  = cs_n;
    end
  end

  task automatic push(input logic c, input logic s, input logic m,
                      input logic b, input logic d);
    exp_t e;
    e = '{cs_n: c, sck: s, mosi: m, busy: b, done: d};
    q.push_back(e);
  endtask

  task automatic frame(input string t, input logic rd, input logic [7:0] op,
                       input logic [23:0] a, input logic [7:0] wd,
                       input logic [7:0] gap, input logic [7:0] fb);
    logic [7:0] bytes [0:4];
    int n;
    logic lastbit;
    do begin @(posedge clk); #1; end while (q.size() != 0);
    tag        = t;
    flash_byte = fb;
    bytes[0] = op; bytes[1] = a[23:16]; bytes[2] = a[15:8];
    bytes[3] = a[7:0]; bytes[4] = wd;
    if (rd) bytes[1] = 8'h00;
    n = rd ? 2 : 5;
    exp_rises = 8 * n;
    push(1'b1, 1'b0, m_mosi, 1'b0, 1'b0);          // start cycle
    push(1'b0, 1'b0, bytes[0][7], 1'b1, 1'b0);     // R7 setup
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        push(1'b0, 1'b1, bytes[k][i], 1'b1, 1'b0);
        if (i > 0) push(1'b0, 1'b0, bytes[k][i-1], 1'b1, 1'b0);
        else if (k < n - 1) begin
          for (int g = 0; g <= int'(gap); g++)
            push(1'b0, 1'b0, bytes[k+1][7], 1'b1, 1'b0);   // R5
        end
      end
    end
    lastbit = bytes[n-1][0];
    push(1'b0, 1'b0, lastbit, 1'b1, 1'b0);           // R7 hold
    for (int g = 0; g < 4; g++) push(1'b1, 1'b0, lastbit, 1'b1, 1'b0);
    push(1'b1, 1'b0, lastbit, 1'b0, 1'b1);           // R8 done
    m_mosi  = lastbit;
    start   = 1'b1;
    rd_mode = rd; opcode = op; addr = a; wdata = wd; gap_len = gap;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (q.size() != 0);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1 cs_n", cs_n, 1);
    check("R1 sck", sck, 0);
    check("R1 mosi", mosi, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    mon_en = 1'b1;

    frame("R4 prog A5@0", 1'b0, 8'h02, 24'h000000, 8'hA5, 8'd0, 8'h00);
    frame("R5 gap3", 1'b0, 8'h02, 24'h123456, 8'h3C, 8'd3, 8'h00);
    frame("R6 read gap2", 1'b1, 8'h05, 24'h0, 8'h00, 8'd2, 8'hC3);
    wait_idle();
    check("R6 rdata C3", rdata, 8'hC3);
    frame("R6 read gap0", 1'b1, 8'h05, 24'h0, 8'h00, 8'd0, 8'h5A);
    wait_idle();
    check("R6 rdata 5A", rdata, 8'h5A);
    frame("R5 gap1 R9 R10", 1'b0, 8'h02, 24'hF0F00F, 8'h81, 8'd1, 8'h00);
    repeat (10) @(posedge clk);
    #1;
    start = 1'b1; rd_mode = 1'b1; opcode = 8'hFF; addr = 24'hFFFFFF;
    wdata = 8'h00; gap_len = 8'd7;
    @(posedge clk); #1;
    start = 1'b0;
    wait_idle();
    check("R10 rdata kept", rdata, 8'h5A);
    check("R9 idle after frame", busy, 0);
    frame("R8 back-to-back", 1'b0, 8'h02, 24'hABCDEF, 8'h77, 8'd0, 8'h00);
    frame("R8 second", 1'b1, 8'h0B, 24'h0, 8'h00, 8'd5, 8'h96);
    wait_idle();
    check("R6 rdata 96", rdata, 8'h96);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule